// File: doc/BRIEF.md
# Bit-Serial Operand Adder

This block adds two unsigned WIDTH-bit numbers one bit position per clock. Both operands are captured in parallel into right-shifting registers. A single-bit carry state machine consumes one bit pair per cycle, lowest position first. Each resulting sum bit enters a result shift register from its top end, so after the last capture the parallel result sits in place with the lowest bit at position 0.

The `MOORE` parameter picks one of two sum-bit styles. With `MOORE` = 0 the sum bit is formed combinationally from the current bit pair and the stored carry, and it is captured in the same cycle. With `MOORE` = 1 the state machine stores the sum bit next to the carry. That bit is captured one cycle later, so a run takes one extra cycle. A run is armed by `load` and started by `start`. `done` rises when the result is complete and stays up, with the result, until the next `load`.

Top module: `serial_add_unit`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, the next state has `done` = 0, `carryOut` = 0 and `sumOut` = 0.
- R2: A cycle with `load` high captures `opA` and `opB`, clears the carry state and the result register, and drops `done`. This happens even while a run is in progress, which is then abandoned.
- R3: With `MOORE` = 0, once `done` is high, `sumOut` equals (`opA` + `opB`) mod 2^WIDTH and `carryOut` equals bit WIDTH of that sum, for the operands of the latest load.
- R4: With `MOORE` = 1, once `done` is high, `sumOut` and `carryOut` hold the same values as in R3.
- R5: `done` first reads 1 exactly WIDTH clock edges (`MOORE` = 0) or WIDTH+1 clock edges (`MOORE` = 1) after the edge that samples `start` following a load.
- R6: While `load` stays low, a high `done` stays high, and `sumOut` and `carryOut` do not change. The carry state changes only in cycles that consume a bit pair.
- R7: `start` is accepted once per load. A `start` with no load since the last accepted start, or with no load since reset, changes neither `done` nor `sumOut` nor `carryOut`.
- R8: The carry state works as two states, no-carry and carry. From no-carry, bit pair 11 moves to carry and any other pair keeps no-carry. From carry, pair 00 moves to no-carry and any other pair keeps carry. The first pair after a load sees no carry-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture both operands and clear the run state |
| opA | input | WIDTH | First operand, unsigned |
| opB | input | WIDTH | Second operand, unsigned |
| start | input | 1 | Begin shifting the loaded operands |
| sumOut | output | WIDTH | Parallel result, low WIDTH bits of the sum |
| carryOut | output | 1 | Carry state; after completion, the carry out of the top bit |
| done | output | 1 | Result complete; held until the next load |

## Verification
`done` is due WIDTH edges after the start edge with a combinational sum bit, and WIDTH+1 edges after it with a registered one. The bench counts edges from the start edge, sampling on the falling clock. It flags a mismatch in either direction. The result and the carry are read only several cycles after `done` is due, so the same read also shows that they are held. The clearing effect of a load is read one falling edge after the load edge. An ignored start is judged after more cycles than any run could take.

// File: rtl/serial_add_pkg.sv
package serial_add_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadOps;     // capture parallel operands, clear result
    logic clearState;  // force the carry machine to its no-carry state
    logic shiftOps;    // consume one bit pair and advance the carry machine
    logic captureSum;  // shift the current sum bit into the result register
  } addStrobe_t;

  typedef enum logic {
    CY_LOW  = 1'b0,
    CY_HIGH = 1'b1
  } mealyCarry_e;

endpackage

// File: rtl/serial_add_carry.sv
module serial_add_carry
  import serial_add_pkg::*;
#(
  parameter bit MOORE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic advance,
  input  logic aBit,
  input  logic bBit,
  output logic sumBit,
  output logic carryBit
);

  generate
    if (!MOORE) begin : g_mealy
      mealyCarry_e cyState;
      mealyCarry_e cyNext;

      always_comb begin
        cyNext = cyState;
        case (cyState)
          CY_LOW:  if (aBit && bBit)   cyNext = CY_HIGH;
          CY_HIGH: if (!aBit && !bBit) cyNext = CY_LOW;
          default: cyNext = CY_LOW;
        endcase
      end

      always_ff @(posedge clk) begin
        if (rst || clear)  cyState <= CY_LOW;
        else if (advance)  cyState <= cyNext;
      end

      logic cyNow;
      assign cyNow    = (cyState == CY_HIGH);
      assign sumBit   = aBit ^ bBit ^ cyNow;
      assign carryBit = cyNow;
    end else begin : g_moore
      // mState[1] holds the carry, mState[0] the registered sum bit
      logic [1:0] mState;
      logic       nxtSum;
      logic       nxtCarry;

      assign nxtSum   = aBit ^ bBit ^ mState[1];
      assign nxtCarry = (aBit & bBit) | (aBit & mState[1]) | (bBit & mState[1]);

      always_ff @(posedge clk) begin
        if (rst || clear)  mState <= 2'b00;
        else if (advance)  mState <= {nxtCarry, nxtSum};
      end

      assign sumBit   = mState[0];
      assign carryBit = mState[1];
    end
  endgenerate

endmodule

// File: rtl/serial_add_dp.sv
module serial_add_dp
  import serial_add_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter bit MOORE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  addStrobe_t       strobe,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut,
  output logic             aBit,
  output logic             bBit
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] aSh;
  logic [WIDTH-1:0] bSh;
  logic [WIDTH-1:0] sumSh;
  logic             sumBit;

  assign aBit = aSh[0];
  assign bBit = bSh[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      aSh <= '0;
      bSh <= '0;
    end else if (strobe.loadOps) begin
      aSh <= opA;
      bSh <= opB;
    end else if (strobe.shiftOps) begin
      aSh <= aSh >> 1;
      bSh <= bSh >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.loadOps)  sumSh <= '0;
    else if (strobe.captureSum) sumSh <= (sumSh >> 1) | (WIDTH'(sumBit) << TOP);
  end

  serial_add_carry #(.MOORE(MOORE)) uCarry (
    .clk     (clk),
    .rst     (rst),
    .clear   (strobe.clearState),
    .advance (strobe.shiftOps),
    .aBit    (aBit),
    .bBit    (bBit),
    .sumBit  (sumBit),
    .carryBit(carryOut)
  );

  assign sumOut = sumSh;

endmodule

// File: rtl/serial_add_ctrl.sv
module serial_add_ctrl
  import serial_add_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter bit MOORE = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       start,
  output addStrobe_t strobe,
  output logic       done
);

  localparam int LAST  = WIDTH - 1 + (MOORE ? 1 : 0);
  localparam int CNT_W = $clog2(LAST + 2);

  logic             armed;
  logic             busy;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
    end else if (load) begin
      armed <= 1'b1;
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
    end else if (start && armed) begin
      armed <= 1'b0;
      busy  <= 1'b1;
      cnt   <= '0;
    end else if (busy) begin
      if (cnt == CNT_W'(LAST)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  logic running;
  assign running = busy && !load;

  always_comb begin
    strobe.loadOps    = load;
    strobe.clearState = load;
    strobe.shiftOps   = running && (cnt < CNT_W'(WIDTH));
    strobe.captureSum = running && (MOORE ? (cnt != '0) : 1'b1);
  end

endmodule

// File: rtl/serial_add_unit.sv
module serial_add_unit
  import serial_add_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter bit MOORE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             start,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut,
  output logic             done
);

  addStrobe_t strobe;
  logic       aBit;
  logic       bBit;
  logic       shiftNow;
  logic       captureNow;

  serial_add_ctrl #(.WIDTH(WIDTH), .MOORE(MOORE)) uCtrl (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .start (start),
    .strobe(strobe),
    .done  (done)
  );

  serial_add_dp #(.WIDTH(WIDTH), .MOORE(MOORE)) uDp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .sumOut  (sumOut),
    .carryOut(carryOut),
    .aBit    (aBit),
    .bBit    (bBit)
  );

  assign shiftNow   = strobe.shiftOps;
  assign captureNow = strobe.captureSum;

endmodule

// File: rtl/serial_add_chk.sv
module serial_add_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             load,
  input logic             done,
  input logic             carryOut,
  input logic [WIDTH-1:0] sumOut,
  input logic             shiftNow,
  input logic             captureNow,
  input logic             aBit,
  input logic             bBit
);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!done && !carryOut && sumOut == '0));  // R1

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    load |=> (!done && !carryOut && sumOut == '0));  // R2

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && !load) |=> (done && $stable(sumOut) && $stable(carryOut)));  // R6

  AST_CARRY_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!shiftNow && !load) |=> $stable(carryOut));  // R6

  AST_DONE_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(captureNow));  // R5

  AST_CARRY_SET: assert property (@(posedge clk) disable iff (rst)
    (shiftNow && !carryOut && aBit && bBit) |=> carryOut);  // R8

  AST_CARRY_DROP: assert property (@(posedge clk) disable iff (rst)
    (shiftNow && carryOut && !aBit && !bBit) |=> !carryOut);  // R8

  AST_CARRY_KEEP: assert property (@(posedge clk) disable iff (rst)
    (shiftNow && (aBit ^ bBit)) |=> $stable(carryOut));  // R8

endmodule

bind serial_add_unit serial_add_chk #(.WIDTH(WIDTH)) uChk (
  .clk       (clk),
  .rst       (rst),
  .load      (load),
  .done      (done),
  .carryOut  (carryOut),
  .sumOut    (sumOut),
  .shiftNow  (shiftNow),
  .captureNow(captureNow),
  .aBit      (aBit),
  .bBit      (bBit)
);

// File: tb/sim_serial_add_unit.sv
`timescale 1ns/100ps
module sim_serial_add_unit;

  localparam int W    = 4;
  localparam int SPAN = 1 << W;

  logic         clk   = 1'b0;
  logic         rst   = 1'b1;
  logic         load  = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] opA   = '0;
  logic [W-1:0] opB   = '0;
  logic [W-1:0] sum0, sum1;
  logic         cy0, cy1, done0, done1;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #2.5 clk = ~clk;

  serial_add_unit #(.WIDTH(W), .MOORE(1'b0)) u0 (
    .clk(clk), .rst(rst), .load(load), .opA(opA), .opB(opB), .start(start),
    .sumOut(sum0), .carryOut(cy0), .done(done0)
  );

  serial_add_unit #(.WIDTH(W), .MOORE(1'b1)) u1 (
    .clk(clk), .rst(rst), .load(load), .opA(opA), .opB(opB), .start(start),
    .sumOut(sum1), .carryOut(cy1), .done(done1)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic doLoad(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    load = 1'b1; opA = a; opB = b;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic pulseStart();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Load, start, then time done and compare the held result in both styles
  task automatic runPair(input logic [W-1:0] a, input logic [W-1:0] b, input bit chkClear);
    int lat0 = 0;
    int lat1 = 0;
    int expv = int'(a) + int'(b);
    doLoad(a, b);
    if (chkClear) begin
      check(!done0 && !cy0 && sum0 == '0, "R2 mealy clear", int'(sum0), 0);
      check(!done1 && !cy1 && sum1 == '0, "R2 moore clear", int'(sum1), 0);
    end
    pulseStart();
    for (int k = 1; k <= W + 3; k++) begin
      @(negedge clk);
      if (done0 && lat0 == 0) lat0 = k;
      if (done1 && lat1 == 0) lat1 = k;
    end
    check(lat0 == W,     "R5 mealy latency", lat0, W);
    check(lat1 == W + 1, "R5 moore latency", lat1, W + 1);
    check(done0 && done1, "R6 done held", int'(done0) + int'(done1), 2);
    check({cy0, sum0} == expv[W:0], "R3 mealy sum", int'({cy0, sum0}), expv);
    check({cy1, sum1} == expv[W:0], "R4 moore sum", int'({cy1, sum1}), expv);
  endtask

  initial begin
    #(100000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!done0 && !cy0 && sum0 == '0, "R1 mealy reset", int'(sum0), 0);
    check(!done1 && !cy1 && sum1 == '0, "R1 moore reset", int'(sum1), 0);
    rst = 1'b0;

    // R7: start with no load since reset does nothing
    @(negedge clk);
    pulseStart();
    repeat (W + 3) @(negedge clk);
    check(!done0 && !done1, "R7 start without load", int'(done0) + int'(done1), 0);

    // R3/R4/R5/R6: exhaustive sweep, includes 0+0 and all-ones plus one
    for (int a = 0; a < SPAN; a++)
      for (int b = 0; b < SPAN; b++)
        runPair(W'(a), W'(b), (a == 0));

    // R7: a second start after completion leaves the result untouched
    runPair(W'(SPAN - 1), W'(1), 1'b0);
    pulseStart();
    repeat (W + 3) @(negedge clk);
    check(done0 && {cy0, sum0} == (W + 1)'(SPAN), "R7 mealy restart ignored", int'({cy0, sum0}), SPAN);
    check(done1 && {cy1, sum1} == (W + 1)'(SPAN), "R7 moore restart ignored", int'({cy1, sum1}), SPAN);

    // R8: carry after the first pair; 1+1 sets carry, no carry-in seen before it
    doLoad(W'(1), W'(1));
    pulseStart();
    @(negedge clk);
    check(cy0 == 1'b1, "R8 mealy carry set on 11", int'(cy0), 1);
    check(cy1 == 1'b1, "R8 moore carry set on 11", int'(cy1), 1);
    @(negedge clk);
    check(cy0 == 1'b0, "R8 mealy carry drop on 00", int'(cy0), 0);
    check(cy1 == 1'b0, "R8 moore carry drop on 00", int'(cy1), 0);

    // R2: load in mid-run abandons it; the new operands are added from a clean state
    doLoad(W'(SPAN - 1), W'(SPAN - 1));
    pulseStart();
    repeat (2) @(negedge clk);
    runPair(W'(5), W'(6), 1'b1);
    check(cy0 == 1'b0 && sum0 == W'(11), "R2 mealy abort result", int'(sum0), 11);
    check(cy1 == 1'b0 && sum1 == W'(11), "R2 moore abort result", int'(sum1), 11);

    // R1: reset after a completed run clears everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!done0 && !cy0 && sum0 == '0, "R1 mealy re-reset", int'(sum0), 0);
    check(!done1 && !cy1 && sum1 == '0, "R1 moore re-reset", int'(sum1), 0);

    finishRun();
  end

endmodule